// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Filter

This block compares a divided oscillator clock against a divided reference clock inside a frequency synthesizer loop. Each rising edge on either input arms a state flag. The first input to rise starts an active-low correction pulse on its opposite path. A reference edge that comes first asks the oscillator to speed up, and an oscillator edge that comes first asks it to slow down. As soon as both flags are armed, a short fixed reset delay runs and then clears them together. Because of this delay, even perfectly aligned inputs produce a pair of equal minimum pulses, and the loop has no dead zone.

Both inputs are assumed to be slow compared with the system clock. They are sampled and edge-detected in the system clock domain, so pulse widths are measured in system clock cycles. A mode input chooses where the correction goes:
- In up/down mode, the pulses appear directly on the two external active-low pins.
- In pump mode, both pins are held low and the pulses drive two active-high internal pump enables instead.

A raw lock signal is high whenever neither pulse is active, which is the AND of the two active-low waveforms. A digital filter measures the width of each pulse burst against a programmable window. It raises the lock flag after a parameterized number of consecutive narrow bursts.

Top module: `pfd_lock_top`

## Requirements
- R1: Only rising edges of `fp_i` and `fc_i` act. A falling edge or a held level produces no pulse.
- R2: When a reference edge precedes an oscillator edge by d cycles, `up_n_o` is low for d+RST_DLY cycles and `dn_n_o` is low for RST_DLY cycles.
- R3: When an oscillator edge precedes a reference edge by d cycles, `dn_n_o` is low for d+RST_DLY cycles and `up_n_o` is low for RST_DLY cycles.
- R4: Edges that arrive in the same cycle give both outputs a pulse of exactly RST_DLY cycles, so there is no dead zone.
- R5: With `mode_i` = 0 (up/down mode), the pulses appear on `up_n_o`/`dn_n_o` (0 = active), and `pump_up_o`/`pump_dn_o` stay 0.
- R6: With `mode_i` = 1 (pump mode), `up_n_o` and `dn_n_o` are held at 0. `pump_up_o`/`pump_dn_o` are 1 for the same cycles in which the pins would have been low.
- R7: `lock_o` rises after LOCK_CYCLES consecutive bursts whose active width is at most `lock_win_i` cycles, and not after fewer.
- R8: In a burst whose active width exceeds `lock_win_i`, `lock_o` is 0 from the cycle after the width passes the window, while the pulse is still active. The count of good bursts restarts.
- R9: If one input keeps toggling while the other stops, the pulse on the opposite path stays continuously asserted.
- R10: While `rst_n` is low at a clock edge, both flags, the delay counter and the lock filter clear. Afterwards the pins are high in up/down mode, the pump enables are 0 and `lock_o` is 0.
- R11: `lock_raw_o` is 1 exactly in the cycles when neither pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fp_i | input | 1 | Divided oscillator clock |
| fc_i | input | 1 | Divided reference clock |
| mode_i | input | 1 | 0 = up/down pins, 1 = internal pump enables |
| lock_win_i | input | WIN_W | Maximum burst width, in cycles, that counts as locked |
| up_n_o | output | 1 | Active-low speed-up pulse pin |
| dn_n_o | output | 1 | Active-low slow-down pulse pin |
| pump_up_o | output | 1 | Active-high source enable in pump mode |
| pump_dn_o | output | 1 | Active-high sink enable in pump mode |
| lock_raw_o | output | 1 | High when no pulse is active |
| lock_o | output | 1 | Filtered lock flag |

## Verification
The assertions assume three things about the inputs:
- `fp_i` and `fc_i` are already synchronous to `clk`.
- Both inputs are low while reset is applied.
- Each input stays high for more than one cycle, so every rising edge is seen once.

The check that both flags clear after the delay also assumes that no new edge lands in the clearing cycle. The stimulus drives both inputs at the falling clock edge and holds them low through every reset. It uses a 24-cycle comparison period with six-cycle high phases and offsets of at most five cycles, so the next edges always arrive well after each burst has finished.

// File: rtl/pfd_pkg.sv
// Shared types for the phase-frequency detector.
// Assumes nothing beyond a 1-bit mode select.
package pfd_pkg;

    // Output routing choice
    typedef enum logic {
        MODE_PINS = 1'b0,
        MODE_PUMP = 1'b1
    } pfd_mode_e;

    // Pair of detector state flags (1 = correction requested)
    typedef struct packed {
        logic up;
        logic dn;
    } pfd_flags_t;

endpackage

// File: rtl/pfd_edge_detect.sv
// Rising-edge detector for a slow input in the clk domain.
// Produces a one-cycle strobe one cycle after the input rises.
// Assumes: the input is synchronous to clk and low during reset.
module pfd_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] pipe_q;

    // Shift the input through the sampling pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[LAST-1:0], sig_i};
        end
    end

    // Strobe when the newer sample is high and the older one is low
    assign rise_o = pipe_q[LAST-1] & ~pipe_q[LAST];

endmodule

// File: rtl/pfd_core.sv
// Edge-armed state flags with a shared, delayed reset.
// A reference strobe arms the up flag and an oscillator strobe arms the dn flag.
// Once both are armed, a counter waits RST_DLY cycles and then clears both.
// Strobes that arrive in the clearing cycle re-arm their flag.
// Assumes: strobes are single-cycle.
module pfd_core
    import pfd_pkg::*;
#(
    parameter int RST_DLY = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise_ref_i,
    input  logic       rise_vco_i,
    output pfd_flags_t flags_o
);
    localparam int DLY_W = $clog2(RST_DLY + 1);
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(RST_DLY - 1);

    pfd_flags_t       flags_q;
    logic [DLY_W-1:0] dly_cnt;
    logic             both_set;

    assign both_set = flags_q.up & flags_q.dn;

    // Arm flags on edges and clear both after the reset delay
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            dly_cnt <= '0;
        end else if (both_set) begin
            if (dly_cnt == DLY_LAST) begin
                flags_q.up <= rise_ref_i;
                flags_q.dn <= rise_vco_i;
                dly_cnt    <= '0;
            end else begin
                dly_cnt <= dly_cnt + 1'b1;
            end
        end else begin
            flags_q.up <= flags_q.up | rise_ref_i;
            flags_q.dn <= flags_q.dn | rise_vco_i;
            dly_cnt    <= '0;
        end
    end

    assign flags_o = flags_q;

    AST_UP_ON_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_ref_i && !both_set) |=> flags_q.up); // R2
    AST_DN_ON_VCO: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_vco_i && !both_set) |=> flags_q.dn); // R3
    AST_BOTH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (both_set && dly_cnt == DLY_LAST && !rise_ref_i && !rise_vco_i)
        |=> (!flags_q.up && !flags_q.dn)); // R4

endmodule

// File: rtl/pfd_lock_filter.sv
// Digital lock filter.
// Measures the active width of each pulse burst, counts consecutive bursts
// that stay within the window, and raises the lock flag at LOCK_CYCLES.
// Lock drops in the cycle after a burst grows past the window.
// Assumes: lock_win_i is stable while bursts are being measured.
module pfd_lock_filter #(
    parameter int WIN_W       = 8,
    parameter int LOCK_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [WIN_W-1:0] win_i,
    output logic             lock_o
);
    localparam int GOOD_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [GOOD_W-1:0] GOOD_MAX  = GOOD_W'(LOCK_CYCLES);
    localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_CYCLES - 1);

    logic              act_q;
    logic              over_q;
    logic              lock_q;
    logic [WIN_W-1:0]  width_cnt;
    logic [GOOD_W-1:0] good_cnt;
    logic              exceed;
    logic              burst_end;

    assign exceed    = active_i && (width_cnt >= win_i);
    assign burst_end = act_q && !active_i;

    // Measure the current burst width (saturating)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_cnt <= '0;
            act_q     <= 1'b0;
        end else begin
            act_q <= active_i;
            if (!active_i) begin
                width_cnt <= '0;
            end else if (width_cnt != '1) begin
                width_cnt <= width_cnt + 1'b1;
            end
        end
    end

    // Count good bursts and drive the lock flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            over_q   <= 1'b0;
            good_cnt <= '0;
            lock_q   <= 1'b0;
        end else if (exceed) begin
            over_q   <= 1'b1;
            good_cnt <= '0;
            lock_q   <= 1'b0;
        end else if (burst_end) begin
            over_q <= 1'b0;
            if (!over_q) begin
                if (good_cnt < GOOD_MAX) begin
                    good_cnt <= good_cnt + 1'b1;
                end
                lock_q <= (good_cnt >= GOOD_LAST);
            end
        end
    end

    assign lock_o = lock_q;

    AST_LOCK_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(!active_i)); // R7
    AST_LOCK_HAS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |-> (good_cnt != '0)); // R7
    AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && width_cnt >= win_i) |=> !lock_o); // R8

endmodule

// File: rtl/pfd_lock_top.sv
// Phase-frequency detector top level.
// Edge detection -> state flags with delayed reset -> mode routing and lock filter.
// Assumes: fp_i and fc_i are synchronous to clk, slow relative to it,
// and low while rst_n is asserted.
module pfd_lock_top
    import pfd_pkg::*;
#(
    parameter int RST_DLY     = 2,
    parameter int LOCK_CYCLES = 4,
    parameter int WIN_W       = 8,
    parameter int EDGE_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fp_i,
    input  logic             fc_i,
    input  logic             mode_i,
    input  logic [WIN_W-1:0] lock_win_i,
    output logic             up_n_o,
    output logic             dn_n_o,
    output logic             pump_up_o,
    output logic             pump_dn_o,
    output logic             lock_raw_o,
    output logic             lock_o
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] rise;
    pfd_flags_t      flags;
    pfd_mode_e       mode;
    logic            active;

    assign raw_in = {fc_i, fp_i};
    assign mode   = pfd_mode_e'(mode_i);

    // One edge detector per compared input
    for (genvar gi = 0; gi < N_IN; gi++) begin : g_edge
        pfd_edge_detect #(
            .STAGES (EDGE_STAGES)
        ) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_i  (raw_in[gi]),
            .rise_o (rise[gi])
        );
    end

    pfd_core #(
        .RST_DLY (RST_DLY)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_ref_i (rise[1]),
        .rise_vco_i (rise[0]),
        .flags_o    (flags)
    );

    assign active = flags.up | flags.dn;

    // Route the pulses to the pins or to the pump enables
    always_comb begin
        if (mode == MODE_PUMP) begin
            up_n_o    = 1'b0;
            dn_n_o    = 1'b0;
            pump_up_o = flags.up;
            pump_dn_o = flags.dn;
        end else begin
            up_n_o    = ~flags.up;
            dn_n_o    = ~flags.dn;
            pump_up_o = 1'b0;
            pump_dn_o = 1'b0;
        end
    end

    assign lock_raw_o = ~active;

    pfd_lock_filter #(
        .WIN_W       (WIN_W),
        .LOCK_CYCLES (LOCK_CYCLES)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .win_i    (lock_win_i),
        .lock_o   (lock_o)
    );

    AST_PUMP_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i |-> (!up_n_o && !dn_n_o)); // R6
    AST_PINMODE_NO_PUMP: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |-> (!pump_up_o && !pump_dn_o)); // R5
    AST_RAW_LOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_raw_o |-> (pump_up_o || pump_dn_o || !up_n_o || !dn_n_o)); // R11

endmodule

// File: tb/pfd_lock_top_tb.sv
// Directed bench for pfd_lock_top: one task per scenario.
module pfd_lock_top_tb;
    localparam int RST_DLY     = 2;
    localparam int LOCK_CYCLES = 4;
    localparam int WIN_W       = 8;
    localparam int PERIOD      = 24;
    localparam int HI          = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fp_i = 1'b0;
    logic             fc_i = 1'b0;
    logic             mode_i = 1'b0;
    logic [WIN_W-1:0] lock_win_i = WIN_W'(4);
    logic             up_n_o, dn_n_o, pump_up_o, pump_dn_o, lock_raw_o, lock_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    // Measurements from the last run_period call
    int  m_up, m_dn, m_pu, m_pd, m_pinhi, m_raw0, m_rawmis;
    bit  m_lock_end, m_lock_at_up;

    always #10 clk = ~clk;

    pfd_lock_top #(
        .RST_DLY     (RST_DLY),
        .LOCK_CYCLES (LOCK_CYCLES),
        .WIN_W       (WIN_W)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fp_i       (fp_i),
        .fc_i       (fc_i),
        .mode_i     (mode_i),
        .lock_win_i (lock_win_i),
        .up_n_o     (up_n_o),
        .dn_n_o     (dn_n_o),
        .pump_up_o  (pump_up_o),
        .pump_dn_o  (pump_dn_o),
        .lock_raw_o (lock_raw_o),
        .lock_o     (lock_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        fp_i  = 1'b0;
        fc_i  = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // One comparison period; a start of -1 means that input stays low
    task automatic run_period(input int ref_start, input int vco_start);
        m_up = 0; m_dn = 0; m_pu = 0; m_pd = 0; m_pinhi = 0; m_raw0 = 0; m_rawmis = 0;
        m_lock_at_up = 1'b0;
        for (int i = 0; i < PERIOD; i++) begin
            @(negedge clk);
            if (!up_n_o) begin m_up++; m_lock_at_up = lock_o; end
            if (!dn_n_o) m_dn++;
            if (pump_up_o) m_pu++;
            if (pump_dn_o) m_pd++;
            if (up_n_o || dn_n_o) m_pinhi++;
            if (!lock_raw_o) m_raw0++;
            if (lock_raw_o != !(pump_up_o || pump_dn_o || (!mode_i && (!up_n_o || !dn_n_o))))
                m_rawmis++;
            fc_i = (ref_start >= 0) && (i >= ref_start) && (i < ref_start + HI);
            fp_i = (vco_start >= 0) && (i >= vco_start) && (i < vco_start + HI);
        end
        m_lock_end = lock_o;
    endtask

    task automatic t_reset_state();
        mode_i = 1'b0;
        do_reset();
        check("R10", "up_n after reset", int'(up_n_o), 1);
        check("R10", "dn_n after reset", int'(dn_n_o), 1);
        check("R10", "pumps after reset", int'(pump_up_o | pump_dn_o), 0);
        check("R10", "lock after reset", int'(lock_o), 0);
        check("R11", "raw lock idle", int'(lock_raw_o), 1);
    endtask

    task automatic t_ref_leads();
        run_period(0, 5);
        check("R2", "up width", m_up, 5 + RST_DLY);
        check("R2", "dn width", m_dn, RST_DLY);
        check("R5", "pump enables in pin mode", m_pu + m_pd, 0);
        check("R11", "raw lock low cycles", m_raw0, 5 + RST_DLY);
        check("R11", "raw lock mismatch", m_rawmis, 0);
    endtask

    task automatic t_vco_leads();
        run_period(3, 0);
        check("R3", "dn width", m_dn, 3 + RST_DLY);
        check("R3", "up width", m_up, RST_DLY);
    endtask

    task automatic t_aligned();
        run_period(0, 0);
        check("R4", "up width aligned", m_up, RST_DLY);
        check("R4", "dn width aligned", m_dn, RST_DLY);
        // falling edges at i=HI occur inside the period; no extra pulse allowed
        check("R1", "no pulse from falling edges", m_up + m_dn, 2 * RST_DLY);
    endtask

    task automatic t_pump_mode();
        mode_i = 1'b1;
        run_period(0, 4);
        check("R6", "pin high samples", m_pinhi, 0);
        check("R6", "pump up width", m_pu, 4 + RST_DLY);
        check("R6", "pump dn width", m_pd, RST_DLY);
        check("R11", "raw lock mismatch pump", m_rawmis, 0);
        mode_i = 1'b0;
        run_period(-1, -1);
    endtask

    task automatic t_lock_acquire();
        lock_win_i = WIN_W'(4);
        do_reset();
        for (int k = 0; k < LOCK_CYCLES - 1; k++) run_period(0, 0);
        check("R7", "lock before N bursts", int'(m_lock_end), 0);
        run_period(0, 0);
        check("R7", "lock after N bursts", int'(m_lock_end), 1);
    endtask

    task automatic t_lock_drop();
        run_period(0, 5);
        check("R8", "lock during wide burst", int'(m_lock_at_up), 0);
        check("R8", "lock after wide burst", int'(m_lock_end), 0);
        for (int k = 0; k < LOCK_CYCLES - 1; k++) run_period(0, 0);
        check("R8", "count restarted", int'(m_lock_end), 0);
        run_period(0, 0);
        check("R7", "relock", int'(m_lock_end), 1);
    endtask

    task automatic t_acquisition();
        int up_total = 0;
        int dn_total = 0;
        do_reset();
        for (int k = 0; k < 3; k++) begin
            run_period(0, -1);
            up_total += m_up;
            dn_total += m_dn;
        end
        check("R9", "up held low", up_total, 3 * PERIOD - 2);
        check("R9", "dn idle", dn_total, 0);
    endtask

    task automatic t_reset_mid();
        do_reset();
        lock_win_i = WIN_W'(4);
        for (int k = 0; k < LOCK_CYCLES; k++) run_period(0, 0);
        @(negedge clk);
        fc_i = 1'b1;
        repeat (4) @(negedge clk);
        check("R2", "up active before reset", int'(up_n_o), 0);
        rst_n = 1'b0;
        fc_i  = 1'b0;
        @(negedge clk);
        check("R10", "up cleared by reset", int'(up_n_o), 1);
        check("R10", "lock cleared by reset", int'(lock_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        t_reset_state();
        t_ref_leads();
        t_vco_leads();
        t_aligned();
        t_pump_mode();
        t_lock_acquire();
        t_lock_drop();
        t_acquisition();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule